// File: doc/BRIEF.md
# Colour Memory Game Controller

This block runs a four-colour memory game. It keeps a growing list of colours, plays that list back on four lamps, and then waits for the player to repeat it on four colour buttons. Each press is compared with the stored entry at the current position. When the whole list has been repeated correctly, one new colour is added and the longer list is played back. A wrong press ends the game. Filling the list to its capacity ends the game as a win.

New colours are not produced by a shift-register generator. A two-bit counter advances on every clock edge, and its value is taken at the moment the player's final correct press of a round is accepted. The unpredictable timing of that press supplies the randomness. The current list length is shown as two BCD digits, which the surrounding logic drives into a pair of seven-segment decoders. Button debouncing happens outside the block, so each button input arrives as a single-cycle pulse.

Top module: `memgame_ctrl`

## Requirements
- R1: While `rst` is high, all lamps are off and both length digits read 0. On the first clock edge after `rst` falls, the first colour is stored and the length becomes 1.
- R2: A colour is the value of a two-bit counter. The counter is cleared by reset and advances by one on every clock edge that is not in reset, so it equals (edges since reset release) mod 4. It is sampled on the first edge after release, and again on the edge that accepts the press completing a round. The sampled value is appended as the newest entry.
- R3: Playback shows the entries in stored order, starting from the first. Colour c lights only `lamp[c]` for T cycles, then all lamps stay dark for T cycles. T is `step_ticks`, or 1 when `step_ticks` is 0.
- R4: Presses are taken only after the dark gap that follows the last entry. A press during playback or during the start-up capture has no effect.
- R5: When several button bits are set in one cycle, only the lowest-numbered set bit counts as the press.
- R6: When the last entry of a round is repeated correctly, the length grows by one and playback of the longer list starts on the next cycle.
- R7: A press that does not match the expected entry enters game over. All four lamps then blink, on for T cycles and off for T cycles, starting with on. The length is held and further presses are ignored until reset.
- R8: Correctly completing a round at the maximum length of 32 enters a win state. All four lamps stay lit and the length digits hold 32, with presses ignored, until reset.
- R9: `len_tens` and `len_ones` are the BCD tens and units digits of the current length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the colour counter advances on each rising edge |
| rst | input | 1 | Synchronous active-high game reset |
| step_ticks | input | 8 | Lamp on time and dark gap length, in cycles (0 is treated as 1) |
| btn | input | 4 | Debounced single-cycle colour press pulses, bit c = colour c |
| lamp | output | 4 | Colour lamp drive, bit c = colour c |
| len_tens | output | 4 | BCD tens digit of the sequence length |
| len_ones | output | 4 | BCD units digit of the sequence length |

## Verification
The assertions assume three things about the inputs. Each button press lasts exactly one clock cycle. `step_ticks` stays constant between resets, so every on period, gap and blink half has the same length. `rst` is held for at least one edge before play begins.

The stimulus respects all three. It drives `btn` for a single cycle at a falling edge and sets `step_ticks` only while reset is held. It times every press from the lamp pattern it has observed, so presses intended as valid land inside the input phase. Presses intended to be ignored are deliberately placed inside playback, capture, game-over or win.

// File: rtl/memgame_pkg.sv
package memgame_pkg;

  typedef enum logic [2:0] {
    PH_SEED,
    PH_ON,
    PH_OFF,
    PH_TAKE,
    PH_LOSE,
    PH_WIN
  } phase_e;

  // One-hot lamp pattern for a colour code.
  function automatic logic [3:0] colour_lamp(input logic [1:0] c);
    return 4'b0001 << c;
  endfunction

  // BCD digits of a small binary count (valid up to 99).
  function automatic logic [3:0] bcd_tens(input int unsigned v);
    return 4'(v / 10);
  endfunction

  function automatic logic [3:0] bcd_ones(input int unsigned v);
    return 4'(v % 10);
  endfunction

endpackage

// File: rtl/memgame_spin.sv
module memgame_spin #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] spin
);
  always_ff @(posedge clk) begin
    if (rst) spin <= '0;
    else     spin <= spin + W'(1);
  end
endmodule

// File: rtl/memgame_press.sv
module memgame_press #(
  parameter int NB = 4,
  parameter int CW = 2
) (
  input  logic [NB-1:0] btn,
  output logic          valid,
  output logic [CW-1:0] colour
);
  always_comb begin
    valid  = |btn;
    colour = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (btn[i]) colour = CW'(i);
    end
  end
endmodule

// File: rtl/memgame_store.sv
module memgame_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/memgame_phase.sv
module memgame_phase
  import memgame_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int TW      = 8,
  localparam int IW     = $clog2(MAX_LEN),
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] step_ticks,
  input  logic          ev_good,
  input  logic          ev_bad,
  input  logic [1:0]    cur_col,
  output phase_e        st,
  output logic [IW-1:0] idx,
  output logic [LW-1:0] len,
  output logic [3:0]    lamp,
  output logic          wr_en,
  output logic [IW-1:0] wr_addr
);
  logic [TW-1:0] timer;
  logic [TW-1:0] ticks_eff;
  logic          tick_end;
  logic          last;
  logic          at_max;
  logic          flash;

  assign ticks_eff = (step_ticks == '0) ? TW'(1) : step_ticks;
  assign tick_end  = (timer == ticks_eff - TW'(1));
  assign last      = ((LW'(idx) + LW'(1)) == len);
  assign at_max    = (len == LW'(MAX_LEN));
  assign wr_en     = (st == PH_SEED) || (ev_good && last && !at_max);
  assign wr_addr   = IW'(len);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PH_SEED;
      len   <= '0;
      idx   <= '0;
      timer <= '0;
      flash <= 1'b0;
    end else begin
      case (st)
        PH_SEED: begin
          len   <= len + LW'(1);
          idx   <= '0;
          timer <= '0;
          st    <= PH_ON;
        end
        PH_ON: begin
          if (tick_end) begin
            timer <= '0;
            st    <= PH_OFF;
          end else begin
            timer <= timer + TW'(1);
          end
        end
        PH_OFF: begin
          if (tick_end) begin
            timer <= '0;
            if (last) begin
              idx <= '0;
              st  <= PH_TAKE;
            end else begin
              idx <= idx + IW'(1);
              st  <= PH_ON;
            end
          end else begin
            timer <= timer + TW'(1);
          end
        end
        PH_TAKE: begin
          if (ev_bad) begin
            flash <= 1'b1;
            timer <= '0;
            st    <= PH_LOSE;
          end else if (ev_good) begin
            if (last) begin
              idx   <= '0;
              timer <= '0;
              if (at_max) begin
                st <= PH_WIN;
              end else begin
                len <= len + LW'(1);
                st  <= PH_ON;
              end
            end else begin
              idx <= idx + IW'(1);
            end
          end
        end
        PH_LOSE: begin
          if (tick_end) begin
            timer <= '0;
            flash <= ~flash;
          end else begin
            timer <= timer + TW'(1);
          end
        end
        default: st <= PH_WIN;
      endcase
    end
  end

  always_comb begin
    case (st)
      PH_ON:   lamp = colour_lamp(cur_col);
      PH_LOSE: lamp = {4{flash}};
      PH_WIN:  lamp = 4'hF;
      default: lamp = 4'h0;
    endcase
  end
endmodule

// File: rtl/memgame_ctrl.sv
module memgame_ctrl
  import memgame_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int TICK_W  = 8,
  localparam int NCOL   = 4,
  localparam int CW     = $clog2(NCOL),
  localparam int IW     = $clog2(MAX_LEN),
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] step_ticks,
  input  logic [NCOL-1:0]   btn,
  output logic [NCOL-1:0]   lamp,
  output logic [3:0]        len_tens,
  output logic [3:0]        len_ones
);
  logic [CW-1:0] spin;
  logic          press_vld;
  logic [CW-1:0] press_col;
  logic [CW-1:0] cur_col;
  phase_e        st;
  logic [IW-1:0] idx;
  logic [LW-1:0] len;
  logic          wr_en;
  logic [IW-1:0] wr_addr;
  logic          ev_take;
  logic          ev_good;
  logic          ev_bad;

  memgame_spin #(.W(CW)) u_spin (
    .clk (clk),
    .rst (rst),
    .spin(spin)
  );

  memgame_press #(.NB(NCOL), .CW(CW)) u_press (
    .btn   (btn),
    .valid (press_vld),
    .colour(press_col)
  );

  memgame_store #(.DEPTH(MAX_LEN), .DW(CW)) u_store (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(spin),
    .raddr(idx),
    .rdata(cur_col)
  );

  // Named press events, visible to the checker.
  assign ev_take = press_vld && (st == PH_TAKE);
  assign ev_bad  = ev_take && (press_col != cur_col);
  assign ev_good = ev_take && (press_col == cur_col);

  memgame_phase #(.MAX_LEN(MAX_LEN), .TW(TICK_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .step_ticks(step_ticks),
    .ev_good   (ev_good),
    .ev_bad    (ev_bad),
    .cur_col   (cur_col),
    .st        (st),
    .idx       (idx),
    .len       (len),
    .lamp      (lamp),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr)
  );

  assign len_tens = bcd_tens(32'(len));
  assign len_ones = bcd_ones(32'(len));
endmodule

// File: rtl/memgame_ctrl_chk.sv
module memgame_ctrl_chk
  import memgame_pkg::*;
#(
  parameter int MAX_LEN = 32,
  localparam int IW     = $clog2(MAX_LEN),
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    btn,
  input logic [3:0]    lamp,
  input logic [3:0]    len_tens,
  input logic [3:0]    len_ones,
  input phase_e        st,
  input logic [IW-1:0] idx,
  input logic [LW-1:0] len,
  input logic [1:0]    spin,
  input logic          ev_good,
  input logic          ev_bad
);
  assert_spin_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> spin == $past(spin) + 2'd1);

  assert_show_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    (st == PH_ON) |-> ($countones(lamp) == 1));

  assert_gap_dark_R3: assert property (@(posedge clk) disable iff (rst)
    (st == PH_OFF || st == PH_TAKE) |-> (lamp == 4'h0));

  assert_idle_press_R4: assert property (@(posedge clk) disable iff (rst)
    ((st == PH_ON || st == PH_OFF) && btn != 4'h0) |=> (st != PH_LOSE && $stable(len)));

  assert_grow_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_good && (int'(idx) + 1 == int'(len)) && int'(len) < MAX_LEN)
      |=> (int'(len) == int'($past(len)) + 1 && st == PH_ON));

  assert_lose_enter_R7: assert property (@(posedge clk) disable iff (rst)
    ev_bad |=> (st == PH_LOSE && lamp == 4'hF));

  assert_lose_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (st == PH_LOSE) |=> (st == PH_LOSE && $stable(len)));

  assert_win_lamps_R8: assert property (@(posedge clk) disable iff (rst)
    (st == PH_WIN) |-> (lamp == 4'hF && int'(len) == MAX_LEN));

  assert_len_cap_R8: assert property (@(posedge clk) disable iff (rst)
    int'(len) <= MAX_LEN);

  assert_bcd_R9: assert property (@(posedge clk) disable iff (rst)
    (int'(len_tens) * 10 + int'(len_ones) == int'(len)) && (len_ones < 4'd10));
endmodule

bind memgame_ctrl memgame_ctrl_chk #(.MAX_LEN(MAX_LEN)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .btn     (btn),
  .lamp    (lamp),
  .len_tens(len_tens),
  .len_ones(len_ones),
  .st      (st),
  .idx     (idx),
  .len     (len),
  .spin    (spin),
  .ev_good (ev_good),
  .ev_bad  (ev_bad)
);

// File: tb/test_memgame_ctrl.sv
module test_memgame_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] step_ticks = 8'd3;
  logic [3:0] btn = 4'h0;
  logic [3:0] lamp;
  logic [3:0] len_tens;
  logic [3:0] len_ones;

  int total = 0;
  int bad   = 0;
  int nedge = 0;
  int pe    = 3;
  int model_seq [0:63];
  int model_len = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) nedge <= 0;
    else     nedge <= nedge + 1;
  end

  memgame_ctrl i_memgame_ctrl (
    .clk       (clk),
    .rst       (rst),
    .step_ticks(step_ticks),
    .btn       (btn),
    .lamp      (lamp),
    .len_tens  (len_tens),
    .len_ones  (len_ones)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lamp_code(input logic [3:0] l);
    int c = -1;
    for (int k = 0; k < 4; k++) if (l[k]) c = k;
    return c;
  endfunction

  task automatic chk_len(input string req);
    int shown = int'(len_tens) * 10 + int'(len_ones);
    chk(len_tens == 4'(model_len / 10) && len_ones == 4'(model_len % 10), req, shown, model_len);
  endtask

  task automatic do_reset(input logic [7:0] p, input logic [3:0] release_btn);
    @(negedge clk);
    rst = 1'b1;
    btn = 4'h0;
    step_ticks = p;
    pe = (p == 8'd0) ? 1 : int'(p);
    repeat (3) @(negedge clk);
    chk(lamp == 4'h0, "R1 lamps in reset", int'(lamp), 0);
    chk(len_tens == 4'd0 && len_ones == 4'd0, "R1 digits in reset",
        int'(len_tens) * 10 + int'(len_ones), 0);
    rst = 1'b0;
    btn = release_btn;
    model_seq[0] = nedge % 4;
    model_len = 1;
    @(negedge clk);
    btn = 4'h0;
    chk_len("R1 length after release");
  endtask

  // Watch one full playback, checking order, on time and gaps.
  task automatic play_check(input bit poke);
    for (int i = 0; i < model_len; i++) begin
      int guard = 0;
      int cnt = 0;
      int gap = 0;
      logic [3:0] col;
      while (lamp == 4'h0 && guard < 1000) begin
        guard++;
        @(negedge clk);
      end
      col = lamp;
      chk($countones(col) == 1, "R3 single lamp", int'(col), 1);
      chk(lamp_code(col) == model_seq[i],
          (i == model_len - 1 && i > 0) ? "R2 newest colour" : "R3 colour order",
          lamp_code(col), model_seq[i]);
      while (lamp == col && cnt < 1000) begin
        btn = (poke && i == 0 && cnt == 0) ? 4'hF : 4'h0;
        cnt++;
        @(negedge clk);
      end
      btn = 4'h0;
      chk(cnt == pe, "R3 on time", cnt, pe);
      if (i < model_len - 1) begin
        while (lamp == 4'h0 && gap < 1000) begin
          gap++;
          @(negedge clk);
        end
        chk(gap == pe, "R3 gap time", gap, pe);
      end else begin
        chk(lamp == 4'h0, "R3 final gap dark", int'(lamp), 0);
        repeat (pe) @(negedge clk);
      end
    end
  endtask

  task automatic press(input logic [3:0] m, output int cap);
    btn = m;
    cap = nedge % 4;
    @(negedge clk);
    btn = 4'h0;
  endtask

  task automatic do_round(input bit multi, input bit poke);
    int cap;
    play_check(poke);
    for (int i = 0; i < model_len; i++) begin
      logic [3:0] m = 4'b0001 << model_seq[i];
      if (multi && model_seq[i] < 3) m = m | 4'b1000;
      press(m, cap);
      if (i < model_len - 1) begin
        chk(lamp == 4'h0, multi ? "R5 lowest bit accepted" : "R4 still taking input", int'(lamp), 0);
      end
    end
    if (model_len < 32) begin
      model_seq[model_len] = cap;
      model_len++;
      chk(lamp != 4'h0 && lamp != 4'hF, "R6 playback restarts", int'(lamp), 1);
      chk_len("R6 length grows");
      chk_len("R9 bcd digits");
    end
  endtask

  // Scenario: capture-phase press ignored, rounds grow, poke during playback.
  task automatic t_basic();
    do_reset(8'd3, 4'b0100);
    do_round(1'b0, 1'b0);
    do_round(1'b0, 1'b1);
    chk_len("R4 playback press ignored");
    do_round(1'b1, 1'b0);
    do_round(1'b0, 1'b0);
  endtask

  // Scenario: wrong press leads to blinking game over.
  task automatic t_lose();
    int cap;
    int on_n = 0;
    int off_n = 0;
    play_check(1'b0);
    press(4'b0001 << ((model_seq[0] + 1) % 4), cap);
    chk(lamp == 4'hF, "R7 all lamps on", int'(lamp), 15);
    chk_len("R7 length held");
    while (lamp == 4'hF && on_n < 100) begin on_n++; @(negedge clk); end
    chk(on_n == pe, "R7 blink on time", on_n, pe);
    while (lamp == 4'h0 && off_n < 100) begin off_n++; @(negedge clk); end
    chk(off_n == pe, "R7 blink off time", off_n, pe);
    press(4'b0001 << model_seq[0], cap);
    press(4'hF, cap);
    chk(lamp == 4'hF || lamp == 4'h0, "R7 still blinking", int'(lamp), 15);
    chk_len("R7 length held after presses");
  endtask

  // Scenario: step_ticks of zero behaves as one.
  task automatic t_zero_ticks();
    do_reset(8'd0, 4'h0);
    do_round(1'b0, 1'b0);
    do_round(1'b0, 1'b0);
  endtask

  // Scenario: fill the list and win.
  task automatic t_win();
    int cap;
    do_reset(8'd1, 4'h0);
    while (model_len < 32) do_round(1'b0, 1'b0);
    chk(len_tens == 4'd3 && len_ones == 4'd2, "R9 digits at 32",
        int'(len_tens) * 10 + int'(len_ones), 32);
    do_round(1'b0, 1'b0);
    chk(lamp == 4'hF, "R8 win lamps", int'(lamp), 15);
    for (int k = 0; k < 6; k++) begin
      press(4'b0001 << (k % 4), cap);
      chk(lamp == 4'hF, "R8 win steady", int'(lamp), 15);
    end
    chk(len_tens == 4'd3 && len_ones == 4'd2, "R8 length held at 32",
        int'(len_tens) * 10 + int'(len_ones), 32);
  endtask

  initial begin
    t_basic();
    t_lose();
    t_zero_ticks();
    t_win();
    do_reset(8'd2, 4'h0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule